// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in, first-out queue that moves 36-bit words in one direction, from a write port to a read port. It stores up to 64 words. Each port runs on its own free-running clock, and the two clocks may be unrelated or may be the same clock. A port moves a word only on the rising edge of its own clock, and only while its enable is high.

The write side shows a full flag and an almost-full flag, both registered in the write clock domain. The read side shows an empty flag and an almost-empty flag, both registered in the read clock domain. Each side sees the other side's pointer as a gray-coded value passed through two flip-flops in its own clock. Two offsets set the thresholds for the "almost" flags. Both offsets are loaded together from the write data bus with a single load pulse, and they hold a default value after reset.

A single asynchronous active-low reset clears the queue. Each clock domain releases the reset on its own clock edge through a two-stage stage.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, and up to 64 words can be held at the same time.
- R2: A word is accepted only on a rising `wclk` edge with `wr_en` high, and a word is delivered only on a rising `rclk` edge with `rd_en` high. While an enable is low, that port's data and flags stay the same.
- R3: A write attempted while `full` is high is dropped. No pointer moves and no stored word is overwritten.
- R4: A read attempted while `empty` is high is dropped. The read pointer does not move and `rd_data` keeps its last value.
- R5: `full` is high exactly when the write side counts 64 stored words.
- R6: `empty` is high exactly when the read side counts zero stored words.
- R7: `almost_full` is high when the free space (64 minus the count) is less than or equal to the almost-full offset.
- R8: `almost_empty` is high when the count is less than or equal to the almost-empty offset.
- R9: Both offsets are 7 bits wide and reset to 8. A `cfg_load` pulse on a `wclk` edge loads the almost-empty offset from `wr_data[6:0]` and the almost-full offset from `wr_data[22:16]`. The load takes effect only while the write side counts zero words. A load cycle never stores a word, even if `wr_en` is high in the same cycle.
- R10: While `rst_n` is low, both pointers are cleared, `empty` and `almost_empty` are high, and `full` and `almost_full` are low.
- R11: Pointers cross between clock domains in gray code, so each pointer changes by at most one bit per edge of its own clock. As a result, R1 to R8 hold both with coincident clocks and with unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| rclk | input | 1 | Read port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Word to write; also carries the offset fields during a load |
| cfg_load | input | 1 | Loads both offsets from `wr_data` (write domain) |
| full | output | 1 | Queue holds 64 words (write domain) |
| almost_full | output | 1 | Free space is at or below the almost-full offset (write domain) |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Last word read, registered on `rclk` |
| empty | output | 1 | Queue holds no words (read domain) |
| almost_empty | output | 1 | Count is at or below the almost-empty offset (read domain) |

## Verification
The almost-empty offset is held in the write domain but is used without synchronization by the read-side compare. The assertions and the read-side flag logic therefore assume that the offset changes only while the queue is empty and no read is in flight. The bench keeps to this rule: it issues a load that takes effect only right after reset, with the queue drained. The load it sends while the queue holds words is dropped by design (R9). The assertions also assume that `rst_n` stays low for at least one edge of each clock. The bench holds reset for several write-clock cycles before it releases it. The bench runs the full fill and drain sweep twice: once with both ports on one clock, and once with a read clock at an unrelated period.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  localparam int unsigned DEF_WORD_W   = 36;
  localparam int unsigned DEF_ADDR_W   = 6;
  localparam int unsigned DEF_OFFSET   = 8;
  // bit positions of the two offset fields inside the write data word
  localparam int unsigned AE_FIELD_LSB = 0;
  localparam int unsigned AF_FIELD_LSB = 16;
endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int unsigned W  = 36,
  parameter int unsigned AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] ram [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata_q <= '0;
    else if (re)  rdata_q <= ram[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xfifo_wr_ctl.sv
module xfifo_wr_ctl #(
  parameter int unsigned AW      = 6,
  parameter int unsigned OFF_DEF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          cfg_load,
  input  logic [AW:0]   cfg_ae,
  input  logic [AW:0]   cfg_af,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          push,
  output logic          full,
  output logic          almost_full,
  output logic [AW:0]   ae_off
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
  localparam logic [PW-1:0] OFF_RST = PW'(OFF_DEF);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] ae_off_q, ae_off_d, af_off_q, af_off_d;
  logic [PW-1:0] rbin_s, cnt_now, cnt_d, free_d;
  logic          full_q, full_d, af_q, af_d, cfg_ok;

  // next-state
  always_comb begin
    rbin_s   = g2b(rgray_s);
    cnt_now  = wbin_q - rbin_s;
    cfg_ok   = cfg_load && (cnt_now == '0);
    push     = wr_en && !cfg_load && !full_q;
    wbin_d   = wbin_q + PW'(push);
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    ae_off_d = cfg_ok ? cfg_ae : ae_off_q;
    af_off_d = cfg_ok ? cfg_af : af_off_q;
    cnt_d    = wbin_d - rbin_s;
    free_d   = DEPTH_P - cnt_d;
    full_d   = (cnt_d == DEPTH_P);
    af_d     = (free_d <= af_off_d);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      ae_off_q <= OFF_RST;
      af_off_q <= OFF_RST;
      full_q   <= 1'b0;
      af_q     <= 1'b0;
    end else begin
      wbin_q   <= wbin_d;
      wgray_q  <= wgray_d;
      ae_off_q <= ae_off_d;
      af_off_q <= af_off_d;
      full_q   <= full_d;
      af_q     <= af_d;
    end
  end

  assign wgray       = wgray_q;
  assign waddr       = wbin_q[AW-1:0];
  assign full        = full_q;
  assign almost_full = af_q;
  assign ae_off      = ae_off_q;

  // R3: a write against a full queue leaves the write pointer alone
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_q) |=> $stable(wbin_q));
  // R5: the write-side count never exceeds the capacity
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_now <= DEPTH_P);
  // R7: a full queue has no free space, so almost-full must also be high
  p_full_af_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> af_q);
  // R11: the gray pointer seen by the other domain moves one bit at a time
  p_wgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/xfifo_rd_ctl.sv
module xfifo_rd_ctl #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   ae_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          pop,
  output logic          empty,
  output logic          almost_empty
);
  localparam int unsigned PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, cnt_d;
  logic          empty_q, empty_d, ae_q, ae_d;

  // next-state
  always_comb begin
    wbin_s  = g2b(wgray_s);
    pop     = rd_en && !empty_q;
    rbin_d  = rbin_q + PW'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    cnt_d   = wbin_s - rbin_d;
    empty_d = (cnt_d == '0);
    ae_d    = (cnt_d <= ae_off);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ae_q    <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
      ae_q    <= ae_d;
    end
  end

  assign rgray        = rgray_q;
  assign raddr        = rbin_q[AW-1:0];
  assign empty        = empty_q;
  assign almost_empty = ae_q;

  // R4: a read against an empty queue leaves the read pointer alone
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty_q) |=> $stable(rbin_q));
  // R8: an empty queue is always at or below any almost-empty offset
  p_empty_ae_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> ae_q);
  // R11: the read gray pointer moves one bit at a time
  p_rgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned OFFSET_DEF = DEF_OFFSET
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_load,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wrst_n, rrst_n;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, ae_off;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              push, pop;

  // per-domain reset release
  xfifo_sync2 #(.W(1)) u_wrst (
    .clk(wclk), .arst_n(rst_n), .d(1'b1), .q(wrst_n));
  xfifo_sync2 #(.W(1)) u_rrst (
    .clk(rclk), .arst_n(rst_n), .d(1'b1), .q(rrst_n));

  // gray pointer crossings
  xfifo_sync2 #(.W(PW)) u_r2w (
    .clk(wclk), .arst_n(wrst_n), .d(rgray), .q(rgray_s));
  xfifo_sync2 #(.W(PW)) u_w2r (
    .clk(rclk), .arst_n(rrst_n), .d(wgray), .q(wgray_s));

  xfifo_wr_ctl #(.AW(ADDR_W), .OFF_DEF(OFFSET_DEF)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .cfg_load(cfg_load),
    .cfg_ae(wr_data[AE_FIELD_LSB +: PW]), .cfg_af(wr_data[AF_FIELD_LSB +: PW]),
    .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .push(push),
    .full(full), .almost_full(almost_full), .ae_off(ae_off));

  xfifo_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .ae_off(ae_off), .rgray(rgray), .raddr(raddr), .pop(pop),
    .empty(empty), .almost_empty(almost_empty));

  xfifo_mem #(.W(WORD_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(pop), .raddr(raddr), .rdata(rd_data));
endmodule

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;
  logic wclk = 1'b0;
  logic rclk_alt = 1'b0;
  logic same_clk = 1'b1;
  wire  rclk = same_clk ? wclk : rclk_alt;

  always #10 wclk = ~wclk;        // 50 MHz
  always #17 rclk_alt = ~rclk_alt; // unrelated read clock

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        cfg_load = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        full, almost_full, empty, almost_empty;

  xclk_fifo uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_load(cfg_load), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int aeo    = 8;
  int afo    = 8;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input int i, input int ph);
    return {4'(ph + 1), 32'(i) * 32'h9E3779B1};
  endfunction

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic check_flags(input int n);
    bit e_full, e_af, e_empty, e_ae;
    e_full  = (n == 64);
    e_af    = ((64 - n) <= afo);
    e_empty = (n == 0);
    e_ae    = (n <= aeo);
    chk(full == e_full, "R5", "full", 36'(full), 36'(e_full));
    chk(almost_full == e_af, "R7", "almost_full", 36'(almost_full), 36'(e_af));
    chk(empty == e_empty, "R6", "empty", 36'(empty), 36'(e_empty));
    chk(almost_empty == e_ae, "R8", "almost_empty", 36'(almost_empty), 36'(e_ae));
  endtask

  task automatic push(input logic [35:0] v);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop(output logic [35:0] v);
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    cfg_load = 1'b0;
    repeat (4) @(negedge wclk);
    // R10: reset state of the flags
    chk(empty == 1'b1, "R10", "empty in reset", 36'(empty), 36'd1);
    chk(almost_empty == 1'b1, "R10", "almost_empty in reset", 36'(almost_empty), 36'd1);
    chk(full == 1'b0, "R10", "full in reset", 36'(full), 36'd0);
    chk(almost_full == 1'b0, "R10", "almost_full in reset", 36'(almost_full), 36'd0);
    rst_n = 1'b1;
    aeo = 8;
    afo = 8;
    settle();
  endtask

  initial begin
    logic [35:0] got;
    for (int ph = 0; ph < 2; ph++) begin
      // phase 0: coincident clocks; phase 1: unrelated clocks (R11)
      same_clk = (ph == 0);
      do_reset();
      check_flags(0); // R9 default offsets of 8

      if (ph == 1) begin
        // R9: load ae=5 from bits 6:0, af=20 from bits 22:16, wr_en high too
        @(negedge wclk);
        cfg_load = 1'b1;
        wr_en = 1'b1;
        wr_data = (36'd20 << 16) | 36'd5;
        @(negedge wclk);
        cfg_load = 1'b0;
        wr_en = 1'b0;
        aeo = 5;
        afo = 20;
        settle();
        check_flags(0); // R9: no word stored by the load cycle, new offsets
      end

      for (int i = 1; i <= 64; i++) begin
        push(pat(i, ph));
        settle();
        check_flags(i); // R1 R11 fill sweep
      end

      // R3: write against full is dropped
      push(36'hF_DEAD_BEEF);
      settle();
      check_flags(64);
      chk(full == 1'b1, "R3", "full after dropped write", 36'(full), 36'd1);

      for (int i = 1; i <= 64; i++) begin
        if (ph == 1 && i == 55) begin
          // R9: load attempt with 10 words stored must be ignored
          @(negedge wclk);
          cfg_load = 1'b1;
          wr_data = (36'd63 << 16) | 36'd63;
          @(negedge wclk);
          cfg_load = 1'b0;
          settle();
          check_flags(10);
        end
        pop(got);
        chk(got == pat(i, ph), "R1 R11", "read order", got, pat(i, ph));
        settle();
        check_flags(64 - i);
      end

      // R4: read against empty is dropped, rd_data holds
      pop(got);
      chk(got == pat(64, ph), "R4", "rd_data after empty read", got, pat(64, ph));
      settle();
      check_flags(0);

      // R2: data changes with enables low have no effect
      for (int k = 0; k < 6; k++) begin
        @(negedge wclk);
        wr_data = pat(500 + k, ph);
      end
      settle();
      check_flags(0);
      chk(rd_data == pat(64, ph), "R2", "rd_data idle", rd_data, pat(64, ph));

      // R4 R3: pointers did not slip, next word comes straight back
      push(pat(200, ph));
      settle();
      check_flags(1);
      pop(got);
      chk(got == pat(200, ph), "R4", "word after empty read", got, pat(200, ph));
      settle();
      check_flags(0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule